// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider

This block makes a card clock from a reference clock. A 2-bit select input picks a divide ratio of 1, 2, 4 or 8. Neighbouring codes differ in one bit, so a select that moves one step at a time never passes through a false code while it is being sampled. The reference clock is the only clock in the block. The select is brought in through a two-stage synchroniser and then held back by a fixed delay. The divider adopts a new ratio only at the end of a complete output period, so no runt or shortened phase ever reaches the card.

An enable input comes from the activation sequencer, which runs on the same reference clock. The output stays low until the sequencer raises the enable. The clock then starts with a full-width high phase. When the enable is dropped, the current output period runs to its end and the output then stays low. Ratios 2, 4 and 8 come from a registered phase counter. Ratio 1 passes the reference clock through a gate that changes only on the falling reference edge. A status output reports that the ratio in use matches the synchronised select.

Top module: `card_clk_div`

## Requirements
- R1: While rst_ni is low, clk_o is low and locked_o is high, because all select tracking resets to code 00.
- R2: With code 00 (divide by 8), 01 (divide by 4) or 11 (divide by 2) selected and the clock running, every output period starts at a rising reference edge. The output is high for N/2 reference cycles and then low for N/2 reference cycles.
- R3: With code 10 (divide by 1) running, clk_o follows the reference clock. It is high during the high half of each reference cycle and low during the low half.
- R4: A select value first sampled at rising edge m can start its first output period no earlier than edge m+8. If the select does not change again, that period starts at the first period boundary at or after edge m+8. Changes must be at least 8 reference cycles apart to be tracked.
- R5: A period boundary is the rising edge that ends the last reference cycle of an output period, or any rising edge while the output is idle. The ratio changes only at a period boundary, so the last period at the old ratio and the first period at the new ratio both have full width.
- R6: No high or low phase of clk_o is shorter than half a reference period, including across any ratio change.
- R7: en_i is sampled at period boundaries. If en_i is low at a boundary, clk_o stays low from that edge on, and a period already under way is never cut short.
- R8: If en_i is high at a rising edge while the output is idle, a new output period starts at that edge with its high phase first, at full width.
- R9: locked_o goes low after edge m+1 for a select change sampled at edge m. It goes high again after the edge at which the first period at the new ratio begins.
- R10: A select change made while the output is idle is adopted at edge m+8 with no activity on clk_o. The next enable then starts the clock at the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable from the activation sequencer, synchronous to clk_i |
| sel_i | input | 2 | Ratio select: 00 is /8, 01 is /4, 11 is /2, 10 is /1 |
| clk_o | output | 1 | Card clock |
| locked_o | output | 1 | High when the active ratio equals the synchronised select |

## Verification
The bench uses the default parameters: two synchroniser stages and an eight-cycle delay. With these, the whole delay window, and every boundary wait at the slowest ratio, fits inside a few dozen reference cycles per step. The bench samples the output once in each half of every reference cycle. This lets it compare the divide-by-1 pass-through phases, and every full-width phase around a switch, against a behavioural model. The bench moves between every pair of ratios, including jumps that skip a code. It also drops and raises the enable at several output phases and changes the select while the output is idle.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int unsigned PH_W  = 3;
  localparam int unsigned CNT_W = PH_W + 1;

  typedef enum logic [1:0] {
    RS_DIV8 = 2'b00,
    RS_DIV4 = 2'b01,
    RS_DIV2 = 2'b11,
    RS_DIV1 = 2'b10
  } ratio_sel_e;

  // log2 of the divide ratio for a select code
  function automatic logic [1:0] sel_log2(input logic [1:0] code);
    case (code)
      RS_DIV8: return 2'd3;
      RS_DIV4: return 2'd2;
      RS_DIV2: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/ccd_sel_track.sv
module ccd_sel_track #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DLY_CYC     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic [1:0] sync_o,
  output logic [1:0] tgt_o,
  output logic       arm_o
);
  // load value chosen so the first commit edge is DLY_CYC after the sample edge
  localparam int unsigned LOAD = DLY_CYC - SYNC_STAGES - 1;
  localparam int unsigned CW   = $clog2(LOAD + 1);

  logic [1:0]    stg_q [SYNC_STAGES];
  logic [1:0]    tgt_q;
  logic [CW-1:0] dcnt_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 2'b00;
        else         stg_q[i] <= sel_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 2'b00;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= 2'b00;
      dcnt_q <= '0;
    end else if (stg_q[SYNC_STAGES-1] != tgt_q) begin
      tgt_q  <= stg_q[SYNC_STAGES-1];
      dcnt_q <= CW'(LOAD);
    end else if (dcnt_q != '0) begin
      dcnt_q <= dcnt_q - 1'b1;
    end
  end

  assign sync_o = stg_q[SYNC_STAGES-1];
  assign tgt_o  = tgt_q;
  assign arm_o  = (dcnt_q == '0);
endmodule

// File: rtl/ccd_phase.sv
module ccd_phase
  import ccd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [1:0]      tgt_i,
  input  logic            arm_i,
  output logic [1:0]      cur_o,
  output logic            run_o,
  output logic [PH_W-1:0] ph_o,
  output logic            tog_o,
  output logic            div1_nxt_o
);
  logic [1:0]       cur_q, cur_d, lg_q, lg_d;
  logic             run_q, run_d, tog_q, tog_d, bnd;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [CNT_W-1:0] per_q, half_d;

  always_comb begin
    lg_q  = sel_log2(cur_q);
    per_q = CNT_W'(1) << lg_q;
    bnd   = !run_q || ({1'b0, ph_q} == per_q - 1'b1);
    run_d = run_q;
    cur_d = cur_q;
    ph_d  = ph_q + 1'b1;
    if (bnd) begin
      run_d = en_i;
      cur_d = arm_i ? tgt_i : cur_q;
      ph_d  = '0;
    end
    lg_d       = sel_log2(cur_d);
    half_d     = (CNT_W'(1) << lg_d) >> 1;
    tog_d      = run_d && (lg_d != 2'd0) && ({1'b0, ph_d} < half_d);
    div1_nxt_o = run_d && (lg_d == 2'd0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= 2'b00;
      run_q <= 1'b0;
      ph_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      run_q <= run_d;
      ph_q  <= ph_d;
      tog_q <= tog_d;
    end
  end

  assign cur_o = cur_q;
  assign run_o = run_q;
  assign ph_o  = ph_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/ccd_out_gate.sv
module ccd_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div1_nxt_i,
  input  logic tog_i,
  output logic clk_o,
  output logic gate_o
);
  logic gate_q;

  // gate moves only while the reference is low, so the AND cannot chop a pulse
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= div1_nxt_i;
  end

  assign clk_o  = tog_i | (clk_i & gate_q);
  assign gate_o = gate_q;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DLY_CYC     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       clk_o,
  output logic       locked_o
);
  import ccd_pkg::*;

  logic [1:0]      sync_w, tgt_w, cur_w;
  logic            arm_w, run_w, tog_w, div1_w, gate_w;
  logic [PH_W-1:0] ph_w;

  ccd_sel_track #(
    .SYNC_STAGES(SYNC_STAGES),
    .DLY_CYC    (DLY_CYC)
  ) u_track (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel_i),
    .sync_o(sync_w),
    .tgt_o (tgt_w),
    .arm_o (arm_w)
  );

  ccd_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tgt_i     (tgt_w),
    .arm_i     (arm_w),
    .cur_o     (cur_w),
    .run_o     (run_w),
    .ph_o      (ph_w),
    .tog_o     (tog_w),
    .div1_nxt_o(div1_w)
  );

  ccd_out_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div1_nxt_i(div1_w),
    .tog_i     (tog_w),
    .clk_o     (clk_o),
    .gate_o    (gate_w)
  );

  assign locked_o = (cur_w == tgt_w) && (sync_w == tgt_w);
endmodule

// File: rtl/ccd_chk.sv
module ccd_chk
  import ccd_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            locked_o,
  input logic [1:0]      cur_q,
  input logic            run_q,
  input logic [PH_W-1:0] ph_q,
  input logic            tog_q,
  input logic            gate_q,
  input logic            arm_q
);
  function automatic logic [PH_W-1:0] end_ph(input logic [1:0] code);
    logic [CNT_W-1:0] per;
    per = CNT_W'(1) << sel_log2(code);
    return PH_W'(per - 1'b1);
  endfunction

  AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> ($past(!run_q) || ($past(ph_q) == end_ph($past(cur_q))))); // R5

  AST_SWITCH_AFTER_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> $past(arm_q)); // R4

  AST_DIV1_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> !tog_q); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !en_i) |=> (!run_q && !tog_q)); // R7

  AST_START_FULL_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> ((ph_q == '0) && $past(en_i))); // R8

  AST_LOCK_HOLDS_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(cur_q)); // R9
endmodule

bind card_clk_div ccd_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .locked_o(locked_o),
  .cur_q   (cur_w),
  .run_q   (run_w),
  .ph_q    (ph_w),
  .tog_q   (tog_w),
  .gate_q  (gate_w),
  .arm_q   (arm_w)
);

// File: tb/test_card_clk_div.sv
`timescale 1ns/1ps
module test_card_clk_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic       clk_o, locked_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  logic [1:0] hist[$];
  int         t = 0;
  logic [1:0] m_cur = 2'b00;
  bit         m_run = 0;
  int         m_ph = 0;

  card_clk_div i_card_clk_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .sel_i(sel_i), .clk_o(clk_o), .locked_o(locked_o)
  );

  always #2.5 clk_i = ~clk_i;

  function automatic int ratio_of(logic [1:0] c);
    case (c)
      2'b00: return 8;
      2'b01: return 4;
      2'b11: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [1:0] hist_at(int i);
    if (i < 0) return 2'b00;
    return hist[i];
  endfunction

  task automatic check(logic act, logic exp, string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at edge %0d", tag, act, exp, t);
    end
  endtask

  // one reference cycle: model the edge, drive, sample both halves
  task automatic step(bit en, logic [1:0] sel, string tag);
    int  n;
    bit  hi, lo, lk;
    @(posedge clk_i);
    hist.push_back(sel_i);
    n = ratio_of(m_cur);
    if (!m_run || m_ph == n - 1) begin
      m_run = en_i;
      m_cur = hist_at(t - 8);
      m_ph  = 0;
    end else begin
      m_ph++;
    end
    n  = ratio_of(m_cur);
    hi = m_run && ((n == 1) || (m_ph < n / 2));
    lo = m_run && (n > 1) && (m_ph < n / 2);
    lk = (hist_at(t - 1) == m_cur) && (hist_at(t - 2) == m_cur);
    #1 en_i = en; sel_i = sel;
    #0.25;
    check(clk_o, hi, tag);
    check(locked_o, lk, "R9");
    #2.5;
    check(clk_o, lo, tag);
    t++;
  endtask

  task automatic run(bit en, logic [1:0] sel, int cycles, string tag_a, string tag_b);
    for (int i = 0; i < cycles; i++) step(en, sel, (i < 20) ? tag_a : tag_b);
  endtask

  initial begin
    #11;
    check(clk_o, 1'b0, "R1");
    check(locked_o, 1'b1, "R1");
    @(posedge clk_i); #1 rst_ni = 1'b1;
    run(0, 2'b00, 12, "R7",  "R7");
    run(1, 2'b00, 41, "R8",  "R2");
    run(1, 2'b01, 37, "R4",  "R2");
    run(1, 2'b11, 40, "R5",  "R2");
    run(1, 2'b10, 39, "R6",  "R3");
    run(1, 2'b00, 43, "R6",  "R2");
    run(1, 2'b10, 35, "R4",  "R3");
    run(1, 2'b01, 38, "R5",  "R2");
    run(0, 2'b01, 21, "R7",  "R7");
    run(0, 2'b11, 24, "R10", "R10");
    run(1, 2'b11, 33, "R8",  "R2");
    run(1, 2'b00, 45, "R5",  "R2");
    run(0, 2'b00, 22, "R7",  "R7");
    run(1, 2'b10, 30, "R8",  "R3");
    run(0, 2'b10, 20, "R7",  "R7");
    run(1, 2'b10, 25, "R8",  "R3");
    run(1, 2'b11, 30, "R6",  "R2");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule